// File: doc/BRIEF.md
# Time-of-Day Alarm Match and Interrupt Flag Unit

This unit sits next to a clock-calendar counter. It keeps three alarm bytes, one each for seconds, minutes and hours, and it checks them against the live time fields whenever the counter signals that an update has finished. The unit also keeps a small flag register. Each flag records one kind of event: a periodic tick, an alarm hit, or the end of an update.

Each flag is gated by an enable bit from the control logic. When any flag is set and its enable is also set, the combined request is raised and the interrupt line goes high. Software clears the flags by reading the flag register over a simple byte-wide register bus. Nothing is lost when an event lands in the same cycle as that read. An alarm byte whose two upper bits are both 1 acts as a wildcard for its field.

Top module: `alm_irq_core`

## Requirements
- R1: A bus write to address 1 (seconds), 3 (minutes) or 5 (hours) stores the byte as that field's alarm. A read of the same address returns the stored byte.
- R2: In a cycle with `update_evt` high, the alarm flag (bit 5 of address 12) is set on the next edge when every field matches. A field matches when its alarm byte equals the live time byte, or when the alarm byte has bits 7 and 6 both set. An alarm byte with only bit 7 set is compared exactly.
- R3: `update_evt` sets the update flag (bit 4), and `periodic_evt` sets the periodic flag (bit 6), on the next clock edge.
- R4: Bit 7 of address 12 and `irq` are both high exactly when at least one of these pairs is set: periodic flag with `en_periodic`, alarm flag with `en_alarm`, or update flag with `en_update`.
- R5: A read of address 12 returns the flags as they were before the read. It clears every flag at the closing edge of the read. With no new event, `irq` is low in the next cycle.
- R6: If an event arrives in the same cycle as a read of address 12, its flag is set after the read rather than cleared.
- R7: Bits 3..0 of address 12 always read 0. Address 13 reads 0x80, meaning time and RAM are valid. Any other address reads 0.
- R8: After reset, all flags are clear, all alarm bytes are 0 and `irq` is low.
- R9: The alarm flag is never set in a cycle that follows one without `update_evt`, even when the time fields match the alarm bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| now_sec | input | 8 | Live seconds field |
| now_min | input | 8 | Live minutes field |
| now_hour | input | 8 | Live hours field |
| periodic_evt | input | 1 | One-cycle periodic tick |
| update_evt | input | 1 | One-cycle end-of-update pulse; the time fields are valid during it |
| en_periodic | input | 1 | Enable for the periodic flag |
| en_alarm | input | 1 | Enable for the alarm flag |
| en_update | input | 1 | Enable for the update flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach from the ports is an event pulse in the exact cycle that the flag register is read. In that cycle the clear and the set compete on the same edge. The stimulus reaches it by driving the tick and the read strobe from one bus step. It then checks three things: the read returns the old flags, `irq` stays high, and a second read shows the flag again. The wildcard encoding is reached by writing a mixed set of alarm bytes: 0xC0, 0xFF, and 0x80, which is not a wildcard. An update is then issued with time bytes that differ from the wildcards, and the alarm flag is checked.

// File: rtl/alm_irq_pkg.sv
package alm_irq_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_FIELDS = 3;

  // Event flags kept by the unit; bit order follows the byte layout.
  typedef struct packed {
    logic periodic;
    logic alarm;
    logic update;
  } evt_t;

  // Field i of the alarm bank lives at the odd address 2*i+1.
  function automatic int field_addr(input int idx);
    return 2 * idx + 1;
  endfunction

  // Alarm byte with both upper bits set is a wildcard.
  function automatic logic field_hit(input logic [DATA_W-1:0] alarm,
                                     input logic [DATA_W-1:0] now);
    return (alarm[DATA_W-1] & alarm[DATA_W-2]) | (alarm == now);
  endfunction

  // Combined request from flags and their enables.
  function automatic logic any_request(input evt_t flags, input evt_t enables);
    return |(flags & enables);
  endfunction

  // Byte image of the flag register; low nibble reads zero.
  function automatic logic [DATA_W-1:0] flag_byte(input evt_t flags, input logic req);
    return {req, flags.periodic, flags.alarm, flags.update, 4'b0000};
  endfunction
endpackage

// File: rtl/alm_match_bank.sv
module alm_match_bank
  import alm_irq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]     now_fields,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0]     alarm_regs,
  output logic                                  all_hit
);
  logic [NUM_FIELDS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(field_addr(g));
    logic [DATA_W-1:0] alarm_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        alarm_q <= '0;
      else if (wr_en && (wr_addr == FADDR))
        alarm_q <= wr_data;
    end

    assign alarm_regs[g] = alarm_q;
    assign hit_vec[g]    = field_hit(alarm_q, now_fields[g]);
  end

  assign all_hit = &hit_vec;
endmodule

// File: rtl/alm_flag_reg.sv
module alm_flag_reg
  import alm_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t set_evt,
  input  logic rd_clear,
  output evt_t flags_q
);
  evt_t flags_d;

  // A set in the clearing cycle wins, so no event is lost.
  always_comb begin
    flags_d = rd_clear ? '0 : flags_q;
    flags_d = flags_d | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/alm_read_mux.sv
module alm_read_mux
  import alm_irq_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int FLAG_ADDR = 12,
  parameter int VALID_ADDR = 13
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_regs,
  input  logic [DATA_W-1:0]                 flag_image,
  output logic [DATA_W-1:0]                 rdata
);
  localparam logic [DATA_W-1:0] VALID_BYTE = DATA_W'(1) << (DATA_W - 1);

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(FLAG_ADDR))
      rdata = flag_image;
    else if (addr == ADDR_W'(VALID_ADDR))
      rdata = VALID_BYTE;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (addr == ADDR_W'(field_addr(i)))
        rdata = alarm_regs[i];
    end
  end
endmodule

// File: rtl/alm_irq_core.sv
module alm_irq_core
  import alm_irq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int FLAG_ADDR  = 12,
  parameter int VALID_ADDR = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic              periodic_evt,
  input  logic              update_evt,
  input  logic              en_periodic,
  input  logic              en_alarm,
  input  logic              en_update,
  output logic              irq
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] now_fields;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_regs;
  logic                              all_hit;
  logic                              alarm_hit;
  logic                              flag_rd;
  logic                              alarm_wr;
  logic                              req_any;
  evt_t                              set_evt;
  evt_t                              enables;
  evt_t                              flags_q;
  logic [DATA_W-1:0]                 flag_image;

  assign now_fields = {now_hour, now_min, now_sec};
  assign alarm_wr   = bus_sel & bus_wr;
  assign flag_rd    = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(FLAG_ADDR));

  alm_match_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (alarm_wr),
    .wr_addr    (bus_addr),
    .wr_data    (bus_wdata),
    .now_fields (now_fields),
    .alarm_regs (alarm_regs),
    .all_hit    (all_hit)
  );

  // Compare counts only on a finished update.
  assign alarm_hit = all_hit & update_evt;

  assign set_evt.periodic = periodic_evt;
  assign set_evt.alarm    = alarm_hit;
  assign set_evt.update   = update_evt;

  alm_flag_reg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_evt),
    .rd_clear (flag_rd),
    .flags_q  (flags_q)
  );

  assign enables.periodic = en_periodic;
  assign enables.alarm    = en_alarm;
  assign enables.update   = en_update;

  assign req_any    = any_request(flags_q, enables);
  assign flag_image = flag_byte(flags_q, req_any);
  assign irq        = req_any;

  alm_read_mux #(
    .ADDR_W     (ADDR_W),
    .FLAG_ADDR  (FLAG_ADDR),
    .VALID_ADDR (VALID_ADDR)
  ) u_rmux (
    .addr       (bus_addr),
    .alarm_regs (alarm_regs),
    .flag_image (flag_image),
    .rdata      (bus_rdata)
  );
endmodule

// File: rtl/alm_irq_chk.sv
module alm_irq_chk
  import alm_irq_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic flag_rd,
  input logic periodic_evt,
  input logic update_evt,
  input logic alarm_hit,
  input evt_t flags_q,
  input logic en_periodic,
  input logic en_alarm,
  input logic en_update,
  input logic irq
);
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !periodic_evt && !update_evt) |=> (flags_q == '0) && !irq); // R5

  AST_PERIODIC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_evt |=> flags_q.periodic); // R3

  AST_UPDATE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    update_evt |=> flags_q.update); // R3

  AST_EVENT_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && periodic_evt) |=> flags_q.periodic); // R6

  AST_HIT_SETS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> flags_q.alarm); // R2

  AST_ALARM_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.alarm) |-> $past(update_evt)); // R9

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_periodic || en_alarm || en_update)); // R4
endmodule

bind alm_irq_core alm_irq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flag_rd      (flag_rd),
  .periodic_evt (periodic_evt),
  .update_evt   (update_evt),
  .alarm_hit    (alarm_hit),
  .flags_q      (flags_q),
  .en_periodic  (en_periodic),
  .en_alarm     (en_alarm),
  .en_update    (en_update),
  .irq          (irq)
);

// File: tb/alm_irq_core_bench.sv
`timescale 1ns/1ps
module alm_irq_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic       periodic_evt = 1'b0, update_evt = 1'b0;
  logic       en_periodic = 1'b0, en_alarm = 1'b0, en_update = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  int last_rd;

  // Reference model state
  int m_alarm [3];
  bit m_pf, m_af, m_uf;

  always #4 clk = ~clk;

  alm_irq_core u_alm_irq_core (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .periodic_evt(periodic_evt), .update_evt(update_evt),
    .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
    .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit wild_or_eq(input int a, input int t);
    return (a >= 'hC0) || (a == t);
  endfunction

  function automatic bit m_irq();
    return (m_pf && en_periodic) || (m_af && en_alarm) || (m_uf && en_update);
  endfunction

  function automatic int m_read(input int a);
    case (a)
      1: return m_alarm[0];
      3: return m_alarm[1];
      5: return m_alarm[2];
      12: return (int'(m_irq()) * 128) + (int'(m_pf) * 64) + (int'(m_af) * 32) + (int'(m_uf) * 16);
      13: return 128;
      default: return 0;
    endcase
  endfunction

  // Behavioural model advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_alarm[k]) m_alarm[k] = 0;
      m_pf = 0; m_af = 0; m_uf = 0;
    end else begin
      bit rd_now, hit;
      rd_now = bus_sel && !bus_wr && (bus_addr == 12);
      hit = wild_or_eq(m_alarm[0], now_sec) && wild_or_eq(m_alarm[1], now_min)
            && wild_or_eq(m_alarm[2], now_hour);
      if (rd_now) begin m_pf = 0; m_af = 0; m_uf = 0; end
      if (periodic_evt) m_pf = 1;
      if (update_evt) m_uf = 1;
      if (update_evt && hit) m_af = 1;
      if (bus_sel && bus_wr && (bus_addr == 1 || bus_addr == 3 || bus_addr == 5))
        m_alarm[(int'(bus_addr) - 1) / 2] = int'(bus_wdata);
    end
  end

  // Clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      chk("R4", "irq vs model", int'(irq), int'(m_irq()));
      chk("R7", "rdata vs model", int'(bus_rdata), m_read(int'(bus_addr)));
    end
  end

  task automatic step(input bit sel, input bit wr, input int a, input int wd,
                      input bit tick, input bit upd);
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = 7'(a); bus_wdata = 8'(wd);
    periodic_evt = tick; update_evt = upd;
    #1;
    last_rd = int'(bus_rdata);
    @(posedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    step(1, 1, a, d, 0, 0);
  endtask

  task automatic rd(input int a, output int v);
    step(1, 0, a, 0, 0, 0);
    v = last_rd;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "irq in reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    idle();
    #1 chk("R8", "irq after reset", int'(irq), 0);
    rd(1, v);  chk("R8", "alarm sec reset", v, 0);
    rd(12, v); chk("R8", "flags reset", v, 0);

    // R1: alarm store and readback
    wr(1, 'h10); wr(3, 'h20); wr(5, 'h08);
    rd(1, v); chk("R1", "alarm sec", v, 'h10);
    rd(3, v); chk("R1", "alarm min", v, 'h20);
    rd(5, v); chk("R1", "alarm hour", v, 'h08);

    // R2/R3: exact match on update
    now_sec = 'h10; now_min = 'h20; now_hour = 'h08;
    step(0, 0, 0, 0, 0, 1);
    rd(12, v); chk("R2", "alarm+update flags", v, 'h30);
    rd(12, v); chk("R5", "flags after read", v, 0);

    // R2: mismatch gives update only
    now_sec = 'h11;
    step(0, 0, 0, 0, 0, 1);
    rd(12, v); chk("R2", "mismatch flags", v, 'h10);

    // R2: wildcard bytes
    wr(1, 'hC0); wr(3, 'hFF);
    now_sec = 'h37; now_min = 'h59; now_hour = 'h08;
    step(0, 0, 0, 0, 0, 1);
    rd(12, v); chk("R2", "wildcard match", v, 'h30);
    wr(1, 'h80);
    step(0, 0, 0, 0, 0, 1);
    rd(12, v); chk("R2", "0x80 is not wildcard", v, 'h10);

    // R9: matching time without update
    wr(1, 'h37);
    idle(); idle(); idle();
    rd(12, v); chk("R9", "no compare without update", v, 0);

    // R3/R4: periodic flag and enables
    step(0, 0, 0, 0, 1, 0);
    rd(12, v); chk("R3", "periodic flag", v, 'h40);
    en_alarm = 1'b1;
    step(0, 0, 0, 0, 1, 0);
    #1 chk("R4", "irq masked", int'(irq), 0);
    en_periodic = 1'b1;
    idle();
    #1 chk("R4", "irq enabled", int'(irq), 1);
    rd(12, v); chk("R4", "combined bit", v, 'hC0);
    #1 chk("R5", "irq cleared by read", int'(irq), 0);

    // R6: event in the read cycle
    step(0, 0, 0, 0, 1, 0);
    step(1, 0, 12, 0, 1, 0);
    chk("R6", "read returns old flags", last_rd, 'hC0);
    #1 chk("R6", "irq kept after read", int'(irq), 1);
    rd(12, v); chk("R6", "flag set again", v, 'hC0);

    // R7: fixed reads
    en_periodic = 1'b0; en_alarm = 1'b0;
    rd(13, v); chk("R7", "valid byte", v, 'h80);
    rd(0, v);  chk("R7", "unused addr 0", v, 0);
    rd(2, v);  chk("R7", "unused addr 2", v, 0);
    step(0, 0, 0, 0, 1, 1);
    rd(12, v); chk("R7", "low nibble zero", v & 'h0F, 0);

    // R4: update enable drives irq
    en_update = 1'b1;
    step(0, 0, 0, 0, 0, 1);
    #1 chk("R4", "irq from update", int'(irq), 1);
    rd(12, v); chk("R4", "update with enable", v, 'hB0);
    idle();
    finish_run();
  end
endmodule